// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block sits beside a direct-mapped first-level cache, between that cache and its refill path from the next memory level. It keeps a few whole lines in fully associative storage to absorb conflict misses. When the first-level cache misses, it presents the missing line address. The buffer compares that address against every entry at once. One cycle later it reports either a hit, which carries the line, or a forward, which sends the request on to the slow refill path.

A mode input picks the fill policy at run time. In victim mode the buffer captures the line that the first-level cache throws out on each miss. A hit swaps that evicted line into the entry that held the requested line. In miss-copy mode the buffer ignores evicted lines. Instead it keeps a copy of each line that comes back over the refill path, and a hit leaves the entry in place. Replacement is true least-recently-used, and empty entries are always filled first. A flush input empties the buffer.

Top module: `victim_cache`

## Requirements
- R1: After reset, `hit_valid` and `fwd_valid` are 0, every entry is empty, and the next lookup is answered as a forward.
- R2: A lookup hits only when an entry's stored line address equals `miss_addr` in every bit. An address that differs in one bit is forwarded.
- R3: When a lookup (`miss_valid`=1) hits, `hit_valid` is 1 in the cycle after the lookup and `hit_data` holds that entry's line. `fwd_valid` stays 0 in that cycle.
- R4: When a lookup misses, `fwd_valid` is 1 in the cycle after the lookup with `fwd_addr` equal to the looked-up address, and `hit_valid` is 0.
- R5: In victim mode (`mode`=0), a lookup that misses and has `victim_valid`=1 stores `victim_addr`/`victim_data`. A later lookup of `victim_addr` hits and returns `victim_data`.
- R6: In victim mode, a lookup that hits moves the line out of the buffer. If `victim_valid`=1, the victim line takes over that same entry. A repeated lookup of the requested address is then forwarded, and a lookup of the victim address hits.
- R7: In miss-copy mode (`mode`=1), a `refill_valid` cycle without a lookup stores `refill_addr`/`refill_data`, and `victim_valid` has no effect: the victim address is later forwarded.
- R8: In miss-copy mode, a hit leaves the entry valid, so an identical second lookup hits again with the same line.
- R9: A new line goes into the lowest-numbered empty entry if there is one. Otherwise it replaces the least recently stored or hit entry.
- R10: A `flush` cycle empties every entry, so a line that hit before the flush is forwarded after it.
- R11: `refill_valid` has no effect in victim mode, or in a cycle that also carries a lookup: that refill address is later forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties all entries |
| mode | input | 1 | 0: keep evicted lines, 1: keep refilled lines |
| miss_valid | input | 1 | First-level miss lookup strobe |
| miss_addr | input | ADDR_W (26) | Line address of the missing request |
| victim_valid | input | 1 | An evicted line accompanies the lookup |
| victim_addr | input | ADDR_W (26) | Line address of the evicted line |
| victim_data | input | LINE_W (128) | Evicted line contents |
| refill_valid | input | 1 | Line returning from the next level |
| refill_addr | input | ADDR_W (26) | Line address of the refilled line |
| refill_data | input | LINE_W (128) | Refilled line contents |
| hit_valid | output | 1 | Lookup hit, line delivered |
| hit_data | output | LINE_W (128) | Line delivered on a hit |
| fwd_valid | output | 1 | Lookup missed, request forwarded |
| fwd_addr | output | ADDR_W (26) | Address forwarded to the next level |

## Verification
A corrupt valid bit or tag shows up one cycle after the next lookup of the affected line: the expected hit turns into a forward, or the reverse. A wrong swap or fill slot is invisible until that line is looked up again. It then shows as a forward where a hit was due, or as wrong `hit_data`. A broken age ordering is seen only later, when a full buffer evicts the wrong line and a lookup of the line that should have survived is forwarded. The test sequences are therefore built to revisit each disturbed line right after the operation that disturbed it.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic {
    FILL_VICTIM = 1'b0,
    FILL_MISS   = 1'b1
  } fill_mode_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vc_tag_match.sv
module vc_tag_match #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  localparam int IDX_W  = vc_pkg::idx_bits(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [ADDR_W-1:0]  tags [ENTRIES],
  input  logic [ADDR_W-1:0]  key,
  output logic [ENTRIES-1:0] match,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end

  assign hit = |match;

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = vc_pkg::idx_bits(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid,
  output logic [IDX_W-1:0]   repl_idx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] age_d [ENTRIES];

  always_comb begin
    for (int j = 0; j < ENTRIES; j++) begin
      age_d[j] = age_q[j];
      if (touch_en) begin
        if (IDX_W'(j) == touch_idx)            age_d[j] = '0;
        else if (age_q[j] < age_q[touch_idx])  age_d[j] = age_q[j] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < ENTRIES; j++) age_q[j] <= IDX_W'(j);
    end else if (touch_en) begin
      for (int j = 0; j < ENTRIES; j++) age_q[j] <= age_d[j];
    end
  end

  logic             any_free;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] old_idx;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    old_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (age_q[i] == OLDEST) old_idx = IDX_W'(i);
    end
  end

  assign repl_idx = any_free ? free_idx : old_idx;
endmodule

// File: rtl/vc_store.sv
module vc_store #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int LINE_W  = 128,
  localparam int IDX_W  = vc_pkg::idx_bits(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ADDR_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0]  wr_data,
  input  logic               inv_en,
  input  logic [IDX_W-1:0]   inv_idx,
  output logic [ENTRIES-1:0] valid,
  output logic [ADDR_W-1:0]  tags [ENTRIES],
  output logic [LINE_W-1:0]  lines [ENTRIES]
);
  logic [ENTRIES-1:0] valid_d;

  always_comb begin
    valid_d = valid;
    if (inv_en) valid_d[inv_idx] = 1'b0;
    if (wr_en)  valid_d[wr_idx]  = 1'b1;
    if (flush)  valid_d          = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= '0;
    else        valid <= valid_d;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic load;
    assign load = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (load) begin
        tags[g]  <= wr_tag;
        lines[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
  parameter int ENTRIES    = 4,
  parameter int ADDR_W     = 26,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int LINE_W    = WORD_W * LINE_WORDS,
  localparam int IDX_W     = vc_pkg::idx_bits(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              mode,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              victim_valid,
  input  logic [ADDR_W-1:0] victim_addr,
  input  logic [LINE_W-1:0] victim_data,
  input  logic              refill_valid,
  input  logic [ADDR_W-1:0] refill_addr,
  input  logic [LINE_W-1:0] refill_data,
  output logic              hit_valid,
  output logic [LINE_W-1:0] hit_data,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr
);
  import vc_pkg::*;

  logic [ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]  tag_q  [ENTRIES];
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [ENTRIES-1:0] match_vec;
  logic               lk_hit;
  logic [IDX_W-1:0]   lk_idx;
  logic [IDX_W-1:0]   repl_idx;

  fill_mode_e fill_mode;
  assign fill_mode = fill_mode_e'(mode);

  vc_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .valid(valid_q), .tags(tag_q), .key(miss_addr),
    .match(match_vec), .hit(lk_hit), .hit_idx(lk_idx)
  );

  logic             take_victim, take_refill;
  logic             wr_en, inv_en, touch_en;
  logic [IDX_W-1:0] wr_idx, touch_idx;
  logic [ADDR_W-1:0] wr_tag;
  logic [LINE_W-1:0] wr_data;

  always_comb begin
    take_victim = miss_valid && victim_valid && (fill_mode == FILL_VICTIM);
    take_refill = !miss_valid && refill_valid && (fill_mode == FILL_MISS);
    wr_en     = 1'b0;
    wr_idx    = repl_idx;
    wr_tag    = victim_addr;
    wr_data   = victim_data;
    inv_en    = 1'b0;
    touch_en  = 1'b0;
    touch_idx = repl_idx;
    if (miss_valid && lk_hit) begin
      touch_en  = 1'b1;
      touch_idx = lk_idx;
      if (take_victim) begin
        wr_en  = 1'b1;
        wr_idx = lk_idx;
      end else if (fill_mode == FILL_VICTIM) begin
        inv_en = 1'b1;
      end
    end else if (take_victim) begin
      wr_en    = 1'b1;
      touch_en = 1'b1;
    end else if (take_refill) begin
      wr_en    = 1'b1;
      wr_tag   = refill_addr;
      wr_data  = refill_data;
      touch_en = 1'b1;
    end
  end

  vc_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
    .inv_en(inv_en), .inv_idx(lk_idx),
    .valid(valid_q), .tags(tag_q), .lines(line_q)
  );

  vc_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .valid(valid_q), .repl_idx(repl_idx)
  );

  logic hit_valid_d, fwd_valid_d, hit_load, fwd_load;
  assign hit_load    = miss_valid && lk_hit;
  assign fwd_load    = miss_valid && !lk_hit;
  assign hit_valid_d = hit_load;
  assign fwd_valid_d = fwd_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid <= 1'b0;
      fwd_valid <= 1'b0;
    end else begin
      hit_valid <= hit_valid_d;
      fwd_valid <= fwd_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hit_load) hit_data <= line_q[lk_idx];
    if (fwd_load) fwd_addr <= miss_addr;
  end
endmodule

// File: rtl/victim_cache_checker.sv
module victim_cache_checker #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               miss_valid,
  input logic [ADDR_W-1:0]  miss_addr,
  input logic               hit_valid,
  input logic               fwd_valid,
  input logic [ADDR_W-1:0]  fwd_addr,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] match_vec
);
  p_one_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_valid && fwd_valid));

  p_answer_follows_lookup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> (hit_valid || fwd_valid));

  p_no_spurious_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_valid |=> !(hit_valid || fwd_valid));

  p_fwd_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> (!fwd_valid || fwd_addr == $past(miss_addr)));

  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
endmodule

bind victim_cache victim_cache_checker #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .miss_valid(miss_valid),
  .miss_addr(miss_addr), .hit_valid(hit_valid), .fwd_valid(fwd_valid),
  .fwd_addr(fwd_addr), .valid_q(valid_q), .match_vec(match_vec)
);

// File: tb/test_victim_cache.sv
`timescale 1ns/1ps
module test_victim_cache;
  localparam int ADDR_W = 26;
  localparam int LINE_W = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, mode = 1'b0;
  logic miss_valid = 1'b0, victim_valid = 1'b0, refill_valid = 1'b0;
  logic [ADDR_W-1:0] miss_addr = '0, victim_addr = '0, refill_addr = '0;
  logic [LINE_W-1:0] victim_data = '0, refill_data = '0;
  logic hit_valid, fwd_valid;
  logic [LINE_W-1:0] hit_data;
  logic [ADDR_W-1:0] fwd_addr;

  always #2.5 clk = ~clk;

  victim_cache i_victim_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush), .mode(mode),
    .miss_valid(miss_valid), .miss_addr(miss_addr),
    .victim_valid(victim_valid), .victim_addr(victim_addr), .victim_data(victim_data),
    .refill_valid(refill_valid), .refill_addr(refill_addr), .refill_data(refill_data),
    .hit_valid(hit_valid), .hit_data(hit_data),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr)
  );

  typedef struct {
    logic              hit;
    logic [LINE_W-1:0] data;
    logic [ADDR_W-1:0] addr;
    string             tag;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  bit armed = 1'b0;
  bit done = 1'b0;

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    logic [31:0] w;
    w = {6'h15, a} ^ 32'h5A3C_96E1;
    return {w, ~w, w + 32'd7, {a[12:0], a[25:13], 6'h2B}};
  endfunction

  task automatic lookup(input logic [ADDR_W-1:0] a, input bit vv,
                        input logic [ADDR_W-1:0] va, input bit exp_hit,
                        input logic [LINE_W-1:0] exp_line, input string tag);
    exp_t e;
    @(posedge clk); #1;
    flush = 1'b0; refill_valid = 1'b0;
    miss_valid = 1'b1; miss_addr = a;
    victim_valid = vv; victim_addr = va; victim_data = line_of(va);
    e.hit = exp_hit; e.data = exp_line; e.addr = a; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk); #1;
    miss_valid = 1'b0; victim_valid = 1'b0;
  endtask

  task automatic refill(input logic [ADDR_W-1:0] a);
    @(posedge clk); #1;
    refill_valid = 1'b1; refill_addr = a; refill_data = line_of(a);
    @(posedge clk); #1;
    refill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(posedge clk); #1;
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
  endtask

  // monitor: compares each answer against the scoreboard
  always @(negedge clk) begin
    if (armed) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (hit_valid !== e.hit || fwd_valid !== !e.hit ||
          (e.hit && hit_data !== e.data) || (!e.hit && fwd_addr !== e.addr)) begin
        n_bad++;
        $display("FAIL %s: hit=%0b fwd=%0b data=%h faddr=%h | expected hit=%0b data=%h faddr=%h",
                 e.tag, hit_valid, fwd_valid, hit_data, fwd_addr, e.hit, e.data, e.addr);
      end
    end else if (rst_n && (hit_valid || fwd_valid)) begin
      n_cmp++; n_bad++;
      $display("FAIL R3/R4 unrequested answer: hit=%0b fwd=%0b expected 0/0", hit_valid, fwd_valid);
    end
    armed = miss_valid;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  localparam logic [ADDR_W-1:0] E0 = 26'h0000100, E1 = 26'h0000200, E2 = 26'h0000300;
  localparam logic [ADDR_W-1:0] E3 = 26'h0000400, E4 = 26'h0000500, E5 = 26'h0000600;
  localparam logic [ADDR_W-1:0] E0B = 26'h0000110;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (hit_valid !== 1'b0 || fwd_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset outputs: hit=%0b fwd=%0b expected 0/0", hit_valid, fwd_valid);
    end
    rst_n = 1'b1;

    // victim mode: capture, hit, swap
    lookup(26'h0A0_0001, 1, 26'h0B0_0001, 0, '0, "R1 R4 first lookup forwards");
    lookup(26'h0B0_0001, 1, 26'h0C0_0001, 1, line_of(26'h0B0_0001), "R3 R5 victim line hits");
    lookup(26'h0B0_0001, 0, '0, 0, '0, "R6 swapped-out line forwards");
    lookup(26'h0C0_0001, 0, '0, 1, line_of(26'h0C0_0001), "R6 swapped-in victim hits");
    lookup(26'h0C0_0001, 0, '0, 0, '0, "R6 hit without victim empties entry");

    // full-address compare
    lookup(26'h0D0_0000, 1, 26'h1234567, 0, '0, "R4 miss storing victim");
    lookup(26'h1234566, 0, '0, 0, '0, "R2 one-bit-off address forwards");
    lookup(26'h3234567, 0, '0, 0, '0, "R2 top-bit-off address forwards");
    lookup(26'h1234567, 0, '0, 1, line_of(26'h1234567), "R2 exact address hits");

    // replacement order
    do_flush();
    lookup(26'h0E0_0000, 1, E0, 0, '0, "R9 fill 0");
    lookup(26'h0E0_0001, 1, E1, 0, '0, "R9 fill 1");
    lookup(26'h0E0_0002, 1, E2, 0, '0, "R9 fill 2");
    lookup(26'h0E0_0003, 1, E3, 0, '0, "R9 fill 3");
    lookup(E0, 1, E0B, 1, line_of(E0), "R9 swap makes slot recent");
    lookup(26'h0E0_0004, 1, E4, 0, '0, "R9 fill evicts oldest");
    lookup(E1, 0, '0, 0, '0, "R9 least recent line evicted");
    lookup(E2, 0, '0, 1, line_of(E2), "R9 newer line kept");
    lookup(26'h0E0_0005, 1, E5, 0, '0, "R9 fill into empty slot");
    lookup(E3, 0, '0, 1, line_of(E3), "R9 empty slot used before oldest valid");
    lookup(E5, 0, '0, 1, line_of(E5), "R9 new line present");

    // flush
    do_flush();
    lookup(E0B, 0, '0, 0, '0, "R10 flushed line forwards");
    lookup(E4, 0, '0, 0, '0, "R10 flushed line forwards");

    // refill ignored in victim mode
    refill(26'h0F0_0000);
    lookup(26'h0F0_0000, 0, '0, 0, '0, "R11 refill ignored in victim mode");

    // miss-copy mode
    @(posedge clk); #1; mode = 1'b1;
    lookup(26'h200_0001, 1, 26'h210_0001, 0, '0, "R4 miss-copy forward");
    refill(26'h200_0001);
    lookup(26'h210_0001, 0, '0, 0, '0, "R7 victim ignored in miss-copy mode");
    lookup(26'h200_0001, 0, '0, 1, line_of(26'h200_0001), "R7 refilled line hits");
    lookup(26'h200_0001, 1, 26'h220_0000, 1, line_of(26'h200_0001), "R8 entry kept after hit");
    @(posedge clk); #1;
    refill_valid = 1'b1; refill_addr = 26'h230_0000; refill_data = line_of(26'h230_0000);
    miss_valid = 1'b1; miss_addr = 26'h240_0000;
    begin
      exp_t e;
      e.hit = 0; e.data = '0; e.addr = 26'h240_0000; e.tag = "R4 lookup beside refill";
      exp_q.push_back(e);
    end
    @(posedge clk); #1;
    refill_valid = 1'b0; miss_valid = 1'b0;
    lookup(26'h230_0000, 0, '0, 0, '0, "R11 refill with lookup ignored");

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule